// File: doc/BRIEF.md
# External Memory Read Sequencer

This block turns single-word read requests from a processor core into timed read cycles on an external memory bus. The bus has a shared address bus, a shared data bus and one active-low enable per memory segment. There are two segments: a program segment and a data segment. Each segment takes its cycle length from its own wait-state field in a configuration word. A read with wait count W occupies W+1 clock periods. The block samples the data bus on the rising edge that ends the cycle. It then presents the word to the core with a one-cycle valid pulse.

Two reads can follow each other directly, one from each segment. In that case the memory read first may still be releasing the data bus when the second segment is selected. A delay control bit handles this. When it is set, the data-segment enable goes low one half clock period after its cycle begins, and no enable is asserted during that half period. The enable still returns high on the rising edge that closes the cycle. The core sees a ready signal that stays low while a read is running or queued. A request that arrives during an active cycle is held in a one-entry slot. It starts on the edge that ends the current cycle.

Top module: `ext_mem_seq`

## Requirements
- R1: The wait count of the program segment comes from bits [15:12] of `wait_cfg_i`. The wait count of the data segment comes from bits [3:0].
- R2: A read with wait count W keeps its segment enable low for W+1 clock periods, or W+½ periods when the enable is delayed. W=0 gives a single-period cycle.
- R3: `ab_o` takes the request address on the rising edge that starts a cycle and holds it until the next cycle starts. In back-to-back reads, the new address appears on the same edge at which the previous enable rises.
- R4: `prog_en_no` and `data_en_no` are never low at the same time.
- R5: `seg_i`=0 selects the program segment and `seg_i`=1 the data segment. The program enable always goes low together with the address. The data enable does too when `dly_en_i`=0. When `dly_en_i`=1, the data enable goes low on the falling clock edge after the cycle starts, unless the previous period was also a data read.
- R6: The active enable goes high on the rising edge that ends the cycle. This edge is never delayed. The enable stays low only if the next cycle uses the same segment.
- R7: `rwn_o` is high at all times after reset, since every cycle is a read.
- R8: On the edge that ends a cycle, `rdata_o` captures `db_i` and `rvalid_o` is high for exactly one period.
- R9: `rdy_o` is low whenever a cycle is active or a request is held, and high otherwise.
- R10: A request made during an active cycle is held and starts on the edge that ends that cycle. A request made while idle starts on the next rising edge.
- R11: During and straight after reset, both enables are high, `rdy_o` is high, `rvalid_o` is low and `ab_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both edges are used |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle read request |
| seg_i | input | 1 | Segment of the request: 0 program, 1 data |
| addr_i | input | 16 | Request address |
| wait_cfg_i | input | 16 | Wait-state configuration word |
| dly_en_i | input | 1 | Delay the asserting edge of the data enable |
| rdy_o | output | 1 | High when no read is active or held |
| rvalid_o | output | 1 | One-cycle pulse with captured read data |
| rdata_o | output | 16 | Captured read data |
| ab_o | output | 16 | External address bus |
| db_i | input | 16 | External data bus |
| rwn_o | output | 1 | Read/write strobe, high for read |
| prog_en_no | output | 1 | Program segment enable, active low |
| data_en_no | output | 1 | Data segment enable, active low |

## Verification
The assertions assume that the core never requests while a request is already held. They also assume that `wait_cfg_i` and `dly_en_i` stay constant while a cycle is active or held. The stimulus keeps to both rules. It issues at most two requests back to back and then waits for `rdy_o` to rise. It changes the configuration only while the block is idle. Within those rules it mixes segment orders and wait counts, including zero, with the delay bit both set and clear.

// File: rtl/ems_pkg.sv
package ems_pkg;
  typedef enum logic {SEG_PROG = 1'b0, SEG_DATA = 1'b1} seg_e;
  localparam int unsigned NUM_SEG = 2;
endpackage

// File: rtl/ems_req_hold.sv
module ems_req_hold #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          last_i,
  input  logic          seg_i,
  input  logic [AW-1:0] addr_i,
  output logic          vld_o,
  output logic          seg_o,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      seg_o  <= 1'b0;
      addr_o <= '0;
    end else if (push_i) begin
      vld_o  <= 1'b1;
      seg_o  <= seg_i;
      addr_o <= addr_i;
    end else if (pop_i) begin
      vld_o  <= 1'b0;
    end
  end

  // R10: a held request waits until the running cycle ends
  a_r10_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !last_i) |=> (vld_o && $stable(addr_o)));
endmodule

// File: rtl/ems_wait_ctr.sv
module ems_wait_ctr #(
  parameter int unsigned WW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [WW-1:0] wait_i,
  output logic          active_o,
  output logic          last_o
);
  logic [WW-1:0] cnt_q;

  assign last_o = active_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_o <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= wait_i;
      active_o <= 1'b1;
    end else if (last_o) begin
      active_o <= 1'b0;
    end else if (active_o) begin
      cnt_q    <= cnt_q - 1'b1;
    end
  end

  // R2: a started cycle with nonzero wait cannot end on its first period
  a_r2_no_early_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && wait_i != '0) |=> !last_o);
endmodule

// File: rtl/ems_strobe_gen.sv
module ems_strobe_gen #(
  parameter int unsigned       NSEG     = 2,
  parameter logic [NSEG-1:0]   DLY_MASK = 2'b10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NSEG-1:0] start_sel_i,
  input  logic            last_i,
  input  logic            dly_en_i,
  output logic [NSEG-1:0] en_no
);
  logic [NSEG-1:0] en_r_q, en_f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_r_q <= '0;
    else if (start_i) en_r_q <= start_sel_i;
    else if (last_i)  en_r_q <= '0;
  end

  // falling-edge copy; ANDed in to push the leading edge back half a period
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_f_q <= '0;
    else         en_f_q <= en_r_q;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (DLY_MASK[s]) begin : g_dly
      assign en_no[s] = ~(en_r_q[s] & (en_f_q[s] | ~dly_en_i));
    end else begin : g_nodly
      assign en_no[s] = ~en_r_q[s];
    end
  end

  a_r4_one_en_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~en_no) <= 1);
  a_r4_one_en_neg: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $countones(~en_no) <= 1);
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import ems_pkg::*;
#(
  parameter int unsigned AW            = 16,
  parameter int unsigned DW            = 16,
  parameter int unsigned WW            = 4,
  parameter int unsigned CFG_W         = 16,
  parameter int unsigned PROG_WAIT_LSB = 12,
  parameter int unsigned DATA_WAIT_LSB = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          seg_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CFG_W-1:0] wait_cfg_i,
  input  logic          dly_en_i,
  output logic          rdy_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] ab_o,
  input  logic [DW-1:0] db_i,
  output logic          rwn_o,
  output logic          prog_en_no,
  output logic          data_en_no
);
  localparam int unsigned NSEG = NUM_SEG;

  logic          active, last, take, start, push, pop;
  logic          hold_vld, hold_seg, nxt_seg;
  logic [AW-1:0] hold_addr, nxt_addr;
  logic [WW-1:0] prog_w, data_w, nxt_w;
  logic [NSEG-1:0] start_sel, en_n;

  assign prog_w = wait_cfg_i[PROG_WAIT_LSB +: WW];
  assign data_w = wait_cfg_i[DATA_WAIT_LSB +: WW];

  assign take     = !active || last;
  assign start    = take && (hold_vld || req_i);
  assign pop      = take && hold_vld;
  assign push     = req_i && !(take && !hold_vld);
  assign nxt_seg  = hold_vld ? hold_seg  : seg_i;
  assign nxt_addr = hold_vld ? hold_addr : addr_i;
  assign nxt_w    = (seg_e'(nxt_seg) == SEG_DATA) ? data_w : prog_w;
  assign start_sel = NSEG'(1) << nxt_seg;

  ems_req_hold #(.AW(AW)) u_hold (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .last_i(last),
    .seg_i, .addr_i, .vld_o(hold_vld), .seg_o(hold_seg), .addr_o(hold_addr)
  );

  ems_wait_ctr #(.WW(WW)) u_ctr (
    .clk_i, .rst_ni, .start_i(start), .wait_i(nxt_w),
    .active_o(active), .last_o(last)
  );

  ems_strobe_gen #(.NSEG(NSEG), .DLY_MASK(NSEG'(1) << SEG_DATA)) u_strb (
    .clk_i, .rst_ni, .start_i(start), .start_sel_i(start_sel),
    .last_i(last), .dly_en_i, .en_no(en_n)
  );

  assign prog_en_no = en_n[SEG_PROG];
  assign data_en_no = en_n[SEG_DATA];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ab_o     <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      rwn_o    <= 1'b1;
    end else begin
      rwn_o    <= 1'b1;
      rvalid_o <= last;
      if (start) ab_o    <= nxt_addr;
      if (last)  rdata_o <= db_i;
    end
  end

  assign rdy_o = !(active || hold_vld);

  a_r3_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !last) |=> $stable(ab_o));
  a_r6_trail_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !start) |=> (prog_en_no && data_en_no));
  a_r8_capture_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(!prog_en_no) || $past(!data_en_no)));
  a_r9_rdy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !rdy_o);
endmodule

// File: tb/ext_mem_seq_tb_top.sv
module ext_mem_seq_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, seg_i = 1'b0, dly_en_i = 1'b0;
  logic [15:0] addr_i = '0, wait_cfg_i = '0;
  logic        rdy_o, rvalid_o, rwn_o, prog_en_no, data_en_no;
  logic [15:0] rdata_o, ab_o, db_i;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  function automatic logic [15:0] mem_word(input logic [15:0] a, input logic s);
    return a ^ (s ? 16'hA5A5 : 16'h5A5A);
  endfunction

  assign db_i = !prog_en_no ? mem_word(ab_o, 1'b0) :
                !data_en_no ? mem_word(ab_o, 1'b1) : 16'hFFFF;

  ext_mem_seq dut_i (.*);

  // behavioural reference
  bit          m_act, m_seg, m_rv, m_prev_dat, m_pv, m_pseg;
  int          m_cnt;
  logic [15:0] m_addr, m_rdata, m_paddr;

  function automatic int w_of(input logic s);  // R1
    return s ? int'(wait_cfg_i[3:0]) : int'(wait_cfg_i[15:12]);
  endfunction

  task automatic m_start(input logic s, input logic [15:0] a);
    m_act = 1; m_seg = s; m_addr = a; m_cnt = w_of(s);
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act = 0; m_seg = 0; m_rv = 0; m_prev_dat = 0; m_pv = 0; m_pseg = 0;
      m_cnt = 0; m_addr = '0; m_rdata = '0; m_paddr = '0;
    end else begin
      m_prev_dat = m_act && m_seg;
      m_rv = 0;
      if (m_act) begin
        if (m_cnt == 0) begin
          m_rv = 1; m_rdata = mem_word(m_addr, m_seg); m_act = 0;
        end else m_cnt--;
      end
      if (!m_act && m_pv) begin m_start(m_pseg, m_paddr); m_pv = 0; end
      if (req_i) begin
        if (!m_act) m_start(seg_i, addr_i);
        else begin m_pv = 1; m_pseg = seg_i; m_paddr = addr_i; end
      end
    end
  end

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", r, $time, act, exp);
    end
  endtask

  // rising-edge phase
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      chk("R3 ab", ab_o, m_addr);
      chk("R2 R6 prog_en", 16'(prog_en_no), 16'(!(m_act && !m_seg)));
      chk("R5 data_en first half", 16'(data_en_no),
          16'(!(m_act && m_seg && (!dly_en_i || m_prev_dat))));
      chk("R4 overlap", 16'(prog_en_no | data_en_no), 16'd1);
      chk("R7 rwn", 16'(rwn_o), 16'd1);
      chk("R9 rdy", 16'(rdy_o), 16'(!(m_act || m_pv)));
      chk("R8 rvalid", 16'(rvalid_o), 16'(m_rv));
      if (m_rv) chk("R8 rdata", rdata_o, m_rdata);
    end
  end

  // falling-edge phase
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      chk("R5 data_en second half", 16'(data_en_no), 16'(!(m_act && m_seg)));
      chk("R2 prog_en second half", 16'(prog_en_no), 16'(!(m_act && !m_seg)));
      chk("R4 overlap", 16'(prog_en_no | data_en_no), 16'd1);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      finish_run();
    end
  end

  task automatic issue(input logic s, input logic [15:0] a);
    @(posedge clk_i); #2;
    req_i = 1; seg_i = s; addr_i = a;
    @(posedge clk_i); #2;
    req_i = 0;
  endtask

  task automatic pair(input logic s0, input logic [15:0] a0,
                      input logic s1, input logic [15:0] a1);
    @(posedge clk_i); #2;
    req_i = 1; seg_i = s0; addr_i = a0;
    @(posedge clk_i); #2;
    seg_i = s1; addr_i = a1;
    @(posedge clk_i); #2;
    req_i = 0;
    wait_idle();
  endtask

  task automatic wait_idle();
    do begin @(posedge clk_i); #3; end while (!rdy_o);
    repeat (2) @(posedge clk_i);
  endtask

  initial begin
    #5;
    // R11: reset values
    chk("R11 prog_en", 16'(prog_en_no), 16'd1);
    chk("R11 data_en", 16'(data_en_no), 16'd1);
    chk("R11 rdy", 16'(rdy_o), 16'd1);
    chk("R11 rvalid", 16'(rvalid_o), 16'd0);
    chk("R11 ab", ab_o, 16'h0000);
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    // R1 R5: program W=1 then data W=2, delayed leading edge
    wait_cfg_i = 16'h1002; dly_en_i = 1;
    pair(1'b0, 16'h0100, 1'b1, 16'h8200);
    // R5 delay clear, R10 held data then program
    dly_en_i = 0;
    pair(1'b1, 16'h0011, 1'b0, 16'h0022);
    // R2 zero waits both segments, delay set
    wait_cfg_i = 16'h0000; dly_en_i = 1;
    pair(1'b0, 16'h1234, 1'b1, 16'h4321);
    pair(1'b1, 16'h0A0A, 1'b1, 16'h0B0B);  // R6 same-segment continuation
    // R1 other field values
    wait_cfg_i = 16'h3005;
    issue(1'b0, 16'hF00F); wait_idle();
    issue(1'b1, 16'h0FF0); wait_idle();
    // mixed orders
    for (int i = 0; i < 40; i++) begin
      wait_cfg_i = {4'($urandom_range(0, 5)), 8'h00, 4'($urandom_range(0, 5))};
      dly_en_i = 1'($urandom);
      if (i % 3 == 0) begin
        issue(1'($urandom), 16'($urandom)); wait_idle();
      end else
        pair(1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom));
    end
    finish_run();
  end
endmodule